// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the horizontal sync, vertical sync and display-enable timing for a single display interface. Software programs a handful of timing words through a simple write port and then sets an enable bit. A line counter runs in pixel clocks and wraps at the line period. A second counter also runs in pixel clocks and counts across the whole frame. All vertical events (frame length, vsync width, start and end of the active window) are therefore absolute pixel-clock offsets within the frame, not line numbers. This lets the active window begin and end part-way through a line (a sync skew) and, in an embedded-panel mode, trims the vertical window by the horizontal porches.

During the active window the block passes the upstream pixel through when the source marks it valid. When the source underflows, the block substitutes a programmable fill colour. Outside the window the pixel output is zero. Timing words written while the engine runs are held in a shadow copy and take effect at the next frame boundary. The running frame is never torn.

Top module: `disp_tgen`

## Requirements
- R1: After reset, hsync_o, vsync_o and de_o are low and pix_o is zero. The fill colour register (address 7) resets to 0xFF.
- R2: Setting the enable bit (bit 0 of address 0) starts both counters from zero. hsync_o, vsync_o, de_o and pix_o are registered, so they reflect the counter state one clock earlier.
- R3: Address 1 holds the line period in bits 31:16 and the hsync width in bits 15:0. The line counter wraps after the line period. hsync_o is high while the line count is below the width.
- R4: Address 4 holds the vsync width in pixel clocks. vsync_o is high while the frame count is below it.
- R5: Address 2 holds the last active pixel in bits 31:16 and the first active pixel in bits 15:0. de_o requires the line count to lie between them, inclusive.
- R6: Addresses 5 and 6 hold the active start and end offsets in pixel clocks. de_o also requires the frame count to lie between them, inclusive.
- R7: When the embedded-mode bit (bit 1 of address 0) is set, the vertical start gains the first active pixel position. The vertical end loses the front porch, which is the line period minus the last active pixel minus one.
- R8: While de_o is high, pix_o is src_pix when src_valid is high and the fill colour otherwise. While de_o is low, pix_o is zero.
- R9: Timing words and the embedded-mode bit written while enabled take effect only at the next frame boundary. While disabled, they take effect on the following cycle.
- R10: Clearing the enable bit stops the engine at once. Both counters hold at zero and all outputs go low on the next output update.
- R11: Address 3 holds the frame period in pixel clocks. At the end of the frame the frame counter and the line counter both return to zero, even when the frame period is not a whole number of lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| src_valid | input | 1 | Upstream pixel available this cycle |
| src_pix | input | CW (24) | Upstream pixel value |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Display enable, active high |
| pix_o | output | CW (24) | Output pixel |

## Verification
The bench aims at the inclusive edges of both windows. A design that used a strict compare would drop the first or last active pixel, or the first or last active line. It programs a skewed vertical window that starts mid-line, and then turns on the embedded trim. A wrong sign or a wrong porch in the trim would move de_o by whole porches. It rewrites the timing mid-frame, which catches a design that applies new values at once and tears the frame. It also uses a frame period that is not a whole number of lines, so a line counter that failed to restart at the frame boundary would shift hsync in the next frame. Underflowing source cycles inside and outside the window show whether the fill colour leaks outside the active area or fails to replace a missing pixel.

// File: rtl/disp_tgen_pkg.sv
package disp_tgen_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_HSYNC  = 3'd1,
    A_HDISP  = 3'd2,
    A_FPER   = 3'd3,
    A_VSW    = 3'd4,
    A_VSTART = 3'd5,
    A_VEND   = 3'd6,
    A_FILL   = 3'd7
  } reg_addr_e;

endpackage

// File: rtl/disp_tgen_regs.sv
module disp_tgen_regs
  import disp_tgen_pkg::*;
#(
  parameter int HW = 16,
  parameter int FW = 32,
  parameter int CW = 24,
  parameter int DW = 32,
  parameter logic [CW-1:0] FILL_RST = CW'('hFF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              frame_wrap,
  output logic              en,
  output logic              act_emb,
  output logic [HW-1:0]     act_hper,
  output logic [HW-1:0]     act_hsw,
  output logic [HW-1:0]     act_hfirst,
  output logic [HW-1:0]     act_hlast,
  output logic [FW-1:0]     act_fper,
  output logic [FW-1:0]     act_vsw,
  output logic [FW-1:0]     act_vstart,
  output logic [FW-1:0]     act_vend,
  output logic [CW-1:0]     act_fill
);

  localparam int HI_LSB = DW / 2;

  logic          en_q, en_d;
  logic          sh_emb_q, sh_emb_d;
  logic [HW-1:0] sh_hper_q, sh_hper_d, sh_hsw_q, sh_hsw_d;
  logic [HW-1:0] sh_hfirst_q, sh_hfirst_d, sh_hlast_q, sh_hlast_d;
  logic [FW-1:0] sh_fper_q, sh_fper_d, sh_vsw_q, sh_vsw_d;
  logic [FW-1:0] sh_vstart_q, sh_vstart_d, sh_vend_q, sh_vend_d;
  logic [CW-1:0] sh_fill_q, sh_fill_d;
  logic          load;

  always_comb begin
    en_d        = en_q;
    sh_emb_d    = sh_emb_q;
    sh_hper_d   = sh_hper_q;
    sh_hsw_d    = sh_hsw_q;
    sh_hfirst_d = sh_hfirst_q;
    sh_hlast_d  = sh_hlast_q;
    sh_fper_d   = sh_fper_q;
    sh_vsw_d    = sh_vsw_q;
    sh_vstart_d = sh_vstart_q;
    sh_vend_d   = sh_vend_q;
    sh_fill_d   = sh_fill_q;
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        A_CTRL: begin
          en_d     = wr_data[0];
          sh_emb_d = wr_data[1];
        end
        A_HSYNC: begin
          sh_hper_d = wr_data[HI_LSB +: HW];
          sh_hsw_d  = wr_data[0 +: HW];
        end
        A_HDISP: begin
          sh_hlast_d  = wr_data[HI_LSB +: HW];
          sh_hfirst_d = wr_data[0 +: HW];
        end
        A_FPER:   sh_fper_d   = wr_data[0 +: FW];
        A_VSW:    sh_vsw_d    = wr_data[0 +: FW];
        A_VSTART: sh_vstart_d = wr_data[0 +: FW];
        A_VEND:   sh_vend_d   = wr_data[0 +: FW];
        A_FILL:   sh_fill_d   = wr_data[0 +: CW];
        default:  ;
      endcase
    end
  end

  // Shadow copy moves to the working copy when idle or at frame end.
  assign load = !en_q || frame_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      sh_emb_q    <= 1'b0;
      sh_hper_q   <= '0;
      sh_hsw_q    <= '0;
      sh_hfirst_q <= '0;
      sh_hlast_q  <= '0;
      sh_fper_q   <= '0;
      sh_vsw_q    <= '0;
      sh_vstart_q <= '0;
      sh_vend_q   <= '0;
      sh_fill_q   <= FILL_RST;
    end else if (wr_en) begin
      en_q        <= en_d;
      sh_emb_q    <= sh_emb_d;
      sh_hper_q   <= sh_hper_d;
      sh_hsw_q    <= sh_hsw_d;
      sh_hfirst_q <= sh_hfirst_d;
      sh_hlast_q  <= sh_hlast_d;
      sh_fper_q   <= sh_fper_d;
      sh_vsw_q    <= sh_vsw_d;
      sh_vstart_q <= sh_vstart_d;
      sh_vend_q   <= sh_vend_d;
      sh_fill_q   <= sh_fill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_emb    <= 1'b0;
      act_hper   <= '0;
      act_hsw    <= '0;
      act_hfirst <= '0;
      act_hlast  <= '0;
      act_fper   <= '0;
      act_vsw    <= '0;
      act_vstart <= '0;
      act_vend   <= '0;
      act_fill   <= FILL_RST;
    end else if (load) begin
      act_emb    <= sh_emb_q;
      act_hper   <= sh_hper_q;
      act_hsw    <= sh_hsw_q;
      act_hfirst <= sh_hfirst_q;
      act_hlast  <= sh_hlast_q;
      act_fper   <= sh_fper_q;
      act_vsw    <= sh_vsw_q;
      act_vstart <= sh_vstart_q;
      act_vend   <= sh_vend_q;
      act_fill   <= sh_fill_q;
    end
  end

  assign en = en_q;

endmodule

// File: rtl/disp_tgen_cnt.sv
module disp_tgen_cnt #(
  parameter int HW = 16,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] hper,
  input  logic [FW-1:0] fper,
  output logic [HW-1:0] hcnt,
  output logic [FW-1:0] fcnt,
  output logic          frame_wrap
);

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [FW-1:0] fcnt_q, fcnt_d;
  logic          line_end, frame_end;

  // Extra bit keeps the +1 from wrapping at the top of the range.
  assign line_end  = ({1'b0, hcnt_q} + 1'b1) >= {1'b0, hper};
  assign frame_end = ({1'b0, fcnt_q} + 1'b1) >= {1'b0, fper};
  assign frame_wrap = en && frame_end;

  always_comb begin
    hcnt_d = hcnt_q;
    fcnt_d = fcnt_q;
    if (!en || frame_end) begin
      hcnt_d = '0;
      fcnt_d = '0;
    end else begin
      fcnt_d = fcnt_q + 1'b1;
      hcnt_d = line_end ? '0 : hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      fcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      fcnt_q <= fcnt_d;
    end
  end

  assign hcnt = hcnt_q;
  assign fcnt = fcnt_q;

endmodule

// File: rtl/disp_tgen_dec.sv
module disp_tgen_dec #(
  parameter int HW = 16,
  parameter int FW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          emb,
  input  logic [HW-1:0] hcnt,
  input  logic [FW-1:0] fcnt,
  input  logic [HW-1:0] hper,
  input  logic [HW-1:0] hsw,
  input  logic [HW-1:0] hfirst,
  input  logic [HW-1:0] hlast,
  input  logic [FW-1:0] vsw,
  input  logic [FW-1:0] vstart,
  input  logic [FW-1:0] vend,
  input  logic [CW-1:0] fill,
  input  logic          src_valid,
  input  logic [CW-1:0] src_pix,
  output logic          hs,
  output logic          vs,
  output logic          de,
  output logic [CW-1:0] pix
);

  localparam int EW = FW + 2;

  logic [EW-1:0] v_lo, v_hi, f_lhs;
  logic          h_in, v_in;
  logic          hs_d, vs_d, de_d;
  logic [CW-1:0] pix_d;
  logic          hs_q, vs_q, de_q;
  logic [CW-1:0] pix_q;

  // The front-porch trim is moved to the left side of the compare,
  // so the end bound never goes below zero.
  always_comb begin
    v_lo  = EW'(vstart) + (emb ? EW'(hfirst) : '0);
    v_hi  = EW'(vend) + (emb ? (EW'(hlast) + EW'(1)) : '0);
    f_lhs = EW'(fcnt) + (emb ? EW'(hper) : '0);
    h_in  = (hcnt >= hfirst) && (hcnt <= hlast);
    v_in  = (EW'(fcnt) >= v_lo) && (f_lhs <= v_hi);
    hs_d  = en && (hcnt < hsw);
    vs_d  = en && (fcnt < vsw);
    de_d  = en && h_in && v_in;
    pix_d = de_d ? (src_valid ? src_pix : fill) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      de_q  <= 1'b0;
      pix_q <= '0;
    end else begin
      hs_q  <= hs_d;
      vs_q  <= vs_d;
      de_q  <= de_d;
      pix_q <= pix_d;
    end
  end

  assign hs  = hs_q;
  assign vs  = vs_q;
  assign de  = de_q;
  assign pix = pix_q;

endmodule

// File: rtl/disp_tgen.sv
module disp_tgen
  import disp_tgen_pkg::*;
#(
  parameter int HW = 16,
  parameter int FW = 32,
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              src_valid,
  input  logic [CW-1:0]     src_pix,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [CW-1:0]     pix_o
);

  logic          en, act_emb, frame_wrap;
  logic [HW-1:0] act_hper, act_hsw, act_hfirst, act_hlast, hcnt;
  logic [FW-1:0] act_fper, act_vsw, act_vstart, act_vend, fcnt;
  logic [CW-1:0] act_fill;

  disp_tgen_regs #(.HW(HW), .FW(FW), .CW(CW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .frame_wrap (frame_wrap),
    .en         (en),
    .act_emb    (act_emb),
    .act_hper   (act_hper),
    .act_hsw    (act_hsw),
    .act_hfirst (act_hfirst),
    .act_hlast  (act_hlast),
    .act_fper   (act_fper),
    .act_vsw    (act_vsw),
    .act_vstart (act_vstart),
    .act_vend   (act_vend),
    .act_fill   (act_fill)
  );

  disp_tgen_cnt #(.HW(HW), .FW(FW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .hper       (act_hper),
    .fper       (act_fper),
    .hcnt       (hcnt),
    .fcnt       (fcnt),
    .frame_wrap (frame_wrap)
  );

  disp_tgen_dec #(.HW(HW), .FW(FW), .CW(CW)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .emb       (act_emb),
    .hcnt      (hcnt),
    .fcnt      (fcnt),
    .hper      (act_hper),
    .hsw       (act_hsw),
    .hfirst    (act_hfirst),
    .hlast     (act_hlast),
    .vsw       (act_vsw),
    .vstart    (act_vstart),
    .vend      (act_vend),
    .fill      (act_fill),
    .src_valid (src_valid),
    .src_pix   (src_pix),
    .hs        (hsync_o),
    .vs        (vsync_o),
    .de        (de_o),
    .pix       (pix_o)
  );

endmodule

// File: rtl/disp_tgen_chk.sv
module disp_tgen_chk #(
  parameter int HW = 16,
  parameter int FW = 32,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          frame_wrap,
  input logic [HW-1:0] hcnt,
  input logic [FW-1:0] fcnt,
  input logic [HW-1:0] act_hper,
  input logic [FW-1:0] act_fper,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          de_o,
  input logic [CW-1:0] pix_o
);

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> (hcnt == '0) && (fcnt == '0));

  p_line_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_hper != '0) |-> (hcnt < act_hper));

  p_blank_pix_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> (pix_o == '0));

  p_hold_params_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !frame_wrap) |=> ($stable(act_hper) && $stable(act_fper)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hsync_o && !vsync_o && !de_o));

  p_frame_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_fper != '0) |-> (fcnt < act_fper));

endmodule

bind disp_tgen disp_tgen_chk #(.HW(HW), .FW(FW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .frame_wrap (frame_wrap),
  .hcnt       (hcnt),
  .fcnt       (fcnt),
  .act_hper   (act_hper),
  .act_fper   (act_fper),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .de_o       (de_o),
  .pix_o      (pix_o)
);

// File: tb/sim_disp_tgen.sv
`timescale 1ns/1ps
module sim_disp_tgen;

  localparam int CW = 24;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [31:0]   wr_data;
  logic          src_valid;
  logic [CW-1:0] src_pix;
  logic          hsync_o, vsync_o, de_o;
  logic [CW-1:0] pix_o;

  disp_tgen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .src_valid(src_valid), .src_pix(src_pix),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string phase = "R1 reset";
  int    k     = 0;

  logic [CW+2:0] expq[$];

  // Reference model state, written from the requirements.
  bit     m_en, s_emb, a_emb;
  longint m_h, m_f;
  longint s_hper, s_hsw, s_first, s_last, s_fper, s_vsw, s_vs, s_ve, s_fill;
  longint a_hper, a_hsw, a_first, a_last, a_fper, a_vsw, a_vs, a_ve, a_fill;

  task automatic chk(string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", what, phase, act, exp);
    end
  endtask

  // Monitor: pops the expected outputs for the clock edge just gone.
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [CW+2:0] e;
      e = expq.pop_front();
      chk("R3 hsync", hsync_o, e[CW+2]);
      chk("R4 vsync", vsync_o, e[CW+1]);
      chk("R5/R6/R7 de", de_o, e[CW]);
      chk("R8 pixel", pix_o, e[CW-1:0]);
    end
  end

  // Driver: one call is one clock cycle.
  task automatic step(bit we, logic [2:0] a, logic [31:0] d);
    bit            sv, hs, vs, de, wrap;
    logic [CW-1:0] sp, px;
    longint        vlo, vhi;
    @(negedge clk); #1;
    sv = (k % 7) != 3;
    sp = CW'(k * 24'h010203) ^ 24'h5A5A5A;
    k++;
    wr_en = we; wr_addr = a; wr_data = d;
    src_valid = sv; src_pix = sp;
    vlo = a_vs + (a_emb ? a_first : 0);
    vhi = a_ve - (a_emb ? (a_hper - 1 - a_last) : 0);
    hs = m_en && (m_h < a_hsw);
    vs = m_en && (m_f < a_vsw);
    de = m_en && (m_h >= a_first) && (m_h <= a_last) && (m_f >= vlo) && (m_f <= vhi);
    px = de ? (sv ? sp : CW'(a_fill)) : '0;
    expq.push_back({hs, vs, de, px});
    wrap = m_en && (m_f + 1 >= a_fper);
    if (!m_en || wrap) begin
      a_emb = s_emb; a_hper = s_hper; a_hsw = s_hsw; a_first = s_first;
      a_last = s_last; a_fper = s_fper; a_vsw = s_vsw; a_vs = s_vs;
      a_ve = s_ve; a_fill = s_fill;
    end
    if (!m_en || (m_f + 1 >= a_fper && !(!m_en || wrap))) begin
      m_h = 0; m_f = 0;
    end
    if (m_en) begin
      if (wrap) begin
        m_h = 0; m_f = 0;
      end else begin
        m_f = m_f + 1;
        m_h = (m_h + 1 >= a_hper) ? 0 : m_h + 1;
      end
    end
    if (we) begin
      case (a)
        3'd0: begin m_en = d[0]; s_emb = d[1]; end
        3'd1: begin s_hper = d[31:16]; s_hsw = d[15:0]; end
        3'd2: begin s_last = d[31:16]; s_first = d[15:0]; end
        3'd3: s_fper = d;
        3'd4: s_vsw = d;
        3'd5: s_vs = d;
        3'd6: s_ve = d;
        default: s_fill = d[CW-1:0];
      endcase
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0);
  endtask

  initial begin
    m_en = 0; s_emb = 0; a_emb = 0; m_h = 0; m_f = 0;
    s_hper = 0; s_hsw = 0; s_first = 0; s_last = 0; s_fper = 0;
    s_vsw = 0; s_vs = 0; s_ve = 0; s_fill = 'hFF;
    a_hper = 0; a_hsw = 0; a_first = 0; a_last = 0; a_fper = 0;
    a_vsw = 0; a_vs = 0; a_ve = 0; a_fill = 'hFF;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; src_valid = 0; src_pix = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset hsync", hsync_o, 0);
    chk("R1 reset vsync", vsync_o, 0);
    chk("R1 reset de", de_o, 0);
    chk("R1 reset pixel", pix_o, 0);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 idle de", de_o, 0);

    // Line 16 clocks (sync 2, bp 3, active 8, fp 3), frame 8 lines.
    phase = "R1 R2 R3 R4 R5 R6 R8 base, default fill";
    wr(3'd1, {16'd16, 16'd2});
    wr(3'd2, {16'd12, 16'd5});
    wr(3'd3, 32'd128);
    wr(3'd4, 32'd16);
    wr(3'd5, 32'd48);
    wr(3'd6, 32'd111);
    wr(3'd0, 32'd1);
    idle(300);

    phase = "R2 R10 stop and restart";
    wr(3'd0, 32'd0);
    idle(20);
    wr(3'd0, 32'd1);
    idle(150);

    // Mid-frame rewrite: line 20 clocks, skewed vertical window.
    phase = "R9 update at frame boundary, programmed fill R8";
    wr(3'd1, {16'd20, 16'd3});
    wr(3'd2, {16'd15, 16'd7});
    wr(3'd3, 32'd160);
    wr(3'd4, 32'd20);
    wr(3'd5, 32'd66);
    wr(3'd6, 32'd147);
    wr(3'd7, 32'h123456);
    idle(400);

    phase = "R7 embedded trim";
    wr(3'd0, 32'd3);
    idle(400);

    phase = "R11 frame not a whole number of lines";
    wr(3'd3, 32'd150);
    idle(450);

    phase = "R10 final stop";
    wr(3'd0, 32'd0);
    idle(10);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired [%s]", phase);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule